// File: doc/BRIEF.md
# Dual-Bank Shared RAM Arbiter

This block puts a 32 KB on-chip RAM behind three request ports: an instruction-fetch port, a data port and a DMA port. All traffic from masters outside the processor enters through the DMA port. The instruction port sees the RAM in a window that starts at address zero, so a vector table can sit at the base of memory. The data port sees the same RAM in a second window that starts at 0x10000. Both windows reach the same storage, so a word written through one window can be read back through the other.

The RAM is split into two independent 16 KB banks, selected by offset bit 14. Each bank takes one access per cycle. Requests that target different banks are served in the same cycle. When several ports want the same bank, a fixed priority picks the winner. The losing port keeps its request up and is served in a later cycle. A starvation guard stops the DMA port from being locked out. Grants are combinational in the request cycle. Read data, the valid flag and the error flag are registered and appear one cycle after the grant.

Top module: `dual_bank_ram_arb`

## Requirements
- R1: The instruction port is in its window when address bits [16:15] are 00 (0x0000–0x7FFF). Offset bits [14:0] then pick the byte in the shared RAM.
- R2: The data port is in its window when address bits [16:15] are 10 (0x10000–0x17FFF). The window maps onto the same RAM as the instruction window, so offset X in either window is the same word.
- R3: The DMA port accepts addresses in either window and reaches the same word for the same offset.
- R4: Offset bit 14 selects the bank: 0 selects the low bank and 1 selects the high bank. Each bank serves at most one port per cycle.
- R5: Two in-window requests from different ports to different banks are both granted in the same cycle.
- R6: When ports contend for one bank, the instruction port wins over the data port, and the data port wins over the DMA port. A denied port holds its request and is granted in a later cycle.
- R7: Once an in-window DMA request has been denied for 4 consecutive cycles, it wins its bank on the next cycle, even against the instruction port.
- R8: A granted in-window read raises rvalid for exactly the following cycle, with the word on rdata. A granted write raises neither rvalid nor err.
- R9: On a write, byte strobe bit j enables data bits [8j+7:8j]. Bytes whose strobe bit is low keep their old value.
- R10: A request outside its port's window is granted at once and does not access the RAM. The port's err flag is high in the following cycle, and rvalid stays low.
- R11: While reset is asserted, and in the first cycle after it, all grant, rvalid and err outputs are low when no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ifp_req | input | 1 | Instruction port request |
| ifp_addr | input | 17 | Instruction port byte address |
| ifp_we | input | 1 | Instruction port write enable |
| ifp_wdata | input | 32 | Instruction port write data |
| ifp_be | input | 4 | Instruction port byte strobes |
| ifp_gnt | output | 1 | Instruction port grant (same cycle) |
| ifp_rvalid | output | 1 | Instruction port read data valid |
| ifp_err | output | 1 | Instruction port window error |
| ifp_rdata | output | 32 | Instruction port read data |
| dtp_req | input | 1 | Data port request |
| dtp_addr | input | 17 | Data port byte address |
| dtp_we | input | 1 | Data port write enable |
| dtp_wdata | input | 32 | Data port write data |
| dtp_be | input | 4 | Data port byte strobes |
| dtp_gnt | output | 1 | Data port grant |
| dtp_rvalid | output | 1 | Data port read data valid |
| dtp_err | output | 1 | Data port window error |
| dtp_rdata | output | 32 | Data port read data |
| dma_req | input | 1 | DMA port request |
| dma_addr | input | 17 | DMA port byte address |
| dma_we | input | 1 | DMA port write enable |
| dma_wdata | input | 32 | DMA port write data |
| dma_be | input | 4 | DMA port byte strobes |
| dma_gnt | output | 1 | DMA port grant |
| dma_rvalid | output | 1 | DMA port read data valid |
| dma_err | output | 1 | DMA port window error |
| dma_rdata | output | 32 | DMA port read data |

## Verification
The assertions assume that each requester keeps its request, address, write enable, data and strobes steady until it sees a grant. The starvation and priority properties depend on that, because they count the cycles of one unchanged DMA request. The bench drives inputs only after a clock edge has settled. It keeps every denied request asserted and unchanged until its grant. It drops a request only in the cycle after that request was granted. Reads target only words the bench has already written, so every expected read value is defined.

// File: rtl/dual_bank_ram_arb.sv
module dual_bank_ram_arb #(
  parameter int DW         = 32,
  parameter int AW         = 17,
  parameter int BANK_BYTES = 16384,
  parameter int STARVE_LIM = 4,
  parameter int I_TAG      = 0,
  parameter int D_TAG      = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ifp_req,
  input  logic [AW-1:0] ifp_addr,
  input  logic          ifp_we,
  input  logic [DW-1:0] ifp_wdata,
  input  logic [DW/8-1:0] ifp_be,
  output logic          ifp_gnt,
  output logic          ifp_rvalid,
  output logic          ifp_err,
  output logic [DW-1:0] ifp_rdata,
  input  logic          dtp_req,
  input  logic [AW-1:0] dtp_addr,
  input  logic          dtp_we,
  input  logic [DW-1:0] dtp_wdata,
  input  logic [DW/8-1:0] dtp_be,
  output logic          dtp_gnt,
  output logic          dtp_rvalid,
  output logic          dtp_err,
  output logic [DW-1:0] dtp_rdata,
  input  logic          dma_req,
  input  logic [AW-1:0] dma_addr,
  input  logic          dma_we,
  input  logic [DW-1:0] dma_wdata,
  input  logic [DW/8-1:0] dma_be,
  output logic          dma_gnt,
  output logic          dma_rvalid,
  output logic          dma_err,
  output logic [DW-1:0] dma_rdata
);
  localparam int BW       = DW / 8;
  localparam int WORDS    = BANK_BYTES / BW;
  localparam int OFF_LSB  = $clog2(BW);
  localparam int BANK_BIT = $clog2(BANK_BYTES);
  localparam int WIN_LSB  = BANK_BIT + 1;
  localparam int IDX_W    = BANK_BIT - OFF_LSB;
  localparam int HI_W     = AW - WIN_LSB;
  localparam int CW       = $clog2(STARVE_LIM + 1);

  logic [2:0]    req, we, ok, bk, gnt, won;
  logic [AW-1:0] addr [3];
  logic [DW-1:0] wd   [3];
  logic [BW-1:0] be   [3];
  logic [HI_W-1:0] hi [3];
  logic [1:0]    sel  [2];
  logic [1:0]    act;
  logic [DW-1:0] bq   [2];
  logic [2:0]    rsp_v, rsp_e, rsel;
  logic [CW-1:0] dma_wait;
  logic          boost;

  assign req = {dma_req, dtp_req, ifp_req};
  assign we  = {dma_we, dtp_we, ifp_we};
  assign addr[0] = ifp_addr;  assign addr[1] = dtp_addr;  assign addr[2] = dma_addr;
  assign wd[0]   = ifp_wdata; assign wd[1]   = dtp_wdata; assign wd[2]   = dma_wdata;
  assign be[0]   = ifp_be;    assign be[1]   = dtp_be;    assign be[2]   = dma_be;

  for (genvar p = 0; p < 3; p++) begin : g_port
    assign hi[p] = addr[p][AW-1:WIN_LSB];
    assign bk[p] = addr[p][BANK_BIT];
  end

  assign ok[0] = hi[0] == HI_W'(I_TAG);
  assign ok[1] = hi[1] == HI_W'(D_TAG);
  assign ok[2] = (hi[2] == HI_W'(I_TAG)) || (hi[2] == HI_W'(D_TAG));

  assign boost = dma_wait == CW'(STARVE_LIM);

  for (genvar gb = 0; gb < 2; gb++) begin : g_bank
    logic [2:0]       want;
    logic [DW-1:0]    mem [WORDS];
    logic [DW-1:0]    q;
    logic [IDX_W-1:0] idx;

    for (genvar p = 0; p < 3; p++) begin : g_want
      assign want[p] = req[p] & ok[p] & (bk[p] == 1'(gb));
    end

    always_comb begin
      if (boost && want[2])  sel[gb] = 2'd2;
      else if (want[0])      sel[gb] = 2'd0;
      else if (want[1])      sel[gb] = 2'd1;
      else                   sel[gb] = 2'd2;
    end
    assign act[gb] = |want;
    assign idx = addr[sel[gb]][BANK_BIT-1:OFF_LSB];

    always_ff @(posedge clk) begin
      if (act[gb]) begin
        if (we[sel[gb]]) begin
          for (int j = 0; j < BW; j++)
            if (be[sel[gb]][j]) mem[idx][j*8 +: 8] <= wd[sel[gb]][j*8 +: 8];
        end
        q <= mem[idx];
      end
    end
    assign bq[gb] = q;
  end

  always_comb begin
    won = '0;
    for (int b = 0; b < 2; b++)
      if (act[b]) won[sel[b]] = 1'b1;
  end
  assign gnt = req & (~ok | won);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v    <= '0;
      rsp_e    <= '0;
      rsel     <= '0;
      dma_wait <= '0;
    end else begin
      rsp_v <= gnt & ok & ~we;
      rsp_e <= gnt & ~ok;
      rsel  <= bk;
      if (req[2] && ok[2] && !gnt[2])
        dma_wait <= boost ? dma_wait : dma_wait + 1'b1;
      else
        dma_wait <= '0;
    end
  end

  assign ifp_gnt    = gnt[0];
  assign dtp_gnt    = gnt[1];
  assign dma_gnt    = gnt[2];
  assign ifp_rvalid = rsp_v[0];
  assign dtp_rvalid = rsp_v[1];
  assign dma_rvalid = rsp_v[2];
  assign ifp_err    = rsp_e[0];
  assign dtp_err    = rsp_e[1];
  assign dma_err    = rsp_e[2];
  assign ifp_rdata  = rsp_v[0] ? bq[rsel[0]] : '0;
  assign dtp_rdata  = rsp_v[1] ? bq[rsel[1]] : '0;
  assign dma_rdata  = rsp_v[2] ? bq[rsel[2]] : '0;

  logic unused_lo;
  assign unused_lo = ^{ifp_addr[OFF_LSB-1:0], dtp_addr[OFF_LSB-1:0], dma_addr[OFF_LSB-1:0]};
endmodule

// File: rtl/dual_bank_ram_arb_chk.sv
module dual_bank_ram_arb_chk #(
  parameter int AW         = 17,
  parameter int BANK_BIT   = 14,
  parameter int STARVE_LIM = 4,
  parameter int I_TAG      = 0,
  parameter int D_TAG      = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ifp_req, ifp_we, ifp_gnt, ifp_rvalid, ifp_err,
  input logic [AW-1:0] ifp_addr,
  input logic          dtp_req, dtp_we, dtp_gnt, dtp_rvalid, dtp_err,
  input logic [AW-1:0] dtp_addr,
  input logic          dma_req, dma_we, dma_gnt, dma_rvalid, dma_err,
  input logic [AW-1:0] dma_addr
);
  localparam int HI_W = AW - BANK_BIT - 1;
  localparam int CW   = $clog2(STARVE_LIM + 1);

  logic i_ok, d_ok, m_ok;
  assign i_ok = ifp_addr[AW-1:BANK_BIT+1] == HI_W'(I_TAG);
  assign d_ok = dtp_addr[AW-1:BANK_BIT+1] == HI_W'(D_TAG);
  assign m_ok = (dma_addr[AW-1:BANK_BIT+1] == HI_W'(I_TAG)) ||
                (dma_addr[AW-1:BANK_BIT+1] == HI_W'(D_TAG));

  logic [CW-1:0] denied;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) denied <= '0;
    else if (dma_req && m_ok && !dma_gnt)
      denied <= (denied == CW'(STARVE_LIM)) ? denied : denied + 1'b1;
    else denied <= '0;
  end

  p_one_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifp_gnt && dtp_gnt && i_ok && d_ok && ifp_addr[BANK_BIT] == dtp_addr[BANK_BIT]));

  p_split_banks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ifp_req && i_ok && dtp_req && d_ok && !dma_req &&
     ifp_addr[BANK_BIT] != dtp_addr[BANK_BIT]) |-> (ifp_gnt && dtp_gnt));

  p_ifp_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ifp_req && i_ok && !dma_req) |-> ifp_gnt);

  p_dma_boost_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (denied == CW'(STARVE_LIM) && dma_req && m_ok) |-> dma_gnt);

  p_read_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dtp_gnt && d_ok && !dtp_we) |=> (dtp_rvalid && !dtp_err));

  p_write_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ifp_gnt && i_ok && ifp_we) |=> (!ifp_rvalid && !ifp_err));

  p_window_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !m_ok) |-> dma_gnt ##1 (dma_err && !dma_rvalid));

  p_no_dual_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifp_rvalid && ifp_err) && !(dtp_rvalid && dtp_err) && !(dma_rvalid && dma_err));

  logic unused_chk;
  assign unused_chk = ^{dma_we};
endmodule

bind dual_bank_ram_arb dual_bank_ram_arb_chk #(
  .AW(AW), .BANK_BIT(BANK_BIT), .STARVE_LIM(STARVE_LIM), .I_TAG(I_TAG), .D_TAG(D_TAG)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .ifp_req(ifp_req), .ifp_we(ifp_we), .ifp_gnt(ifp_gnt), .ifp_rvalid(ifp_rvalid),
  .ifp_err(ifp_err), .ifp_addr(ifp_addr),
  .dtp_req(dtp_req), .dtp_we(dtp_we), .dtp_gnt(dtp_gnt), .dtp_rvalid(dtp_rvalid),
  .dtp_err(dtp_err), .dtp_addr(dtp_addr),
  .dma_req(dma_req), .dma_we(dma_we), .dma_gnt(dma_gnt), .dma_rvalid(dma_rvalid),
  .dma_err(dma_err), .dma_addr(dma_addr)
);

// File: tb/dual_bank_ram_arb_tb_top.sv
module dual_bank_ram_arb_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0]  d_req = '0, d_we = '0;
  logic [16:0] d_addr [3];
  logic [31:0] d_wd   [3];
  logic [3:0]  d_be   [3];
  logic [2:0]  gnt, rv, er;
  logic [31:0] rd [3];

  dual_bank_ram_arb dut_i (
    .clk(clk), .rst_n(rst_n),
    .ifp_req(d_req[0]), .ifp_addr(d_addr[0]), .ifp_we(d_we[0]), .ifp_wdata(d_wd[0]), .ifp_be(d_be[0]),
    .ifp_gnt(gnt[0]), .ifp_rvalid(rv[0]), .ifp_err(er[0]), .ifp_rdata(rd[0]),
    .dtp_req(d_req[1]), .dtp_addr(d_addr[1]), .dtp_we(d_we[1]), .dtp_wdata(d_wd[1]), .dtp_be(d_be[1]),
    .dtp_gnt(gnt[1]), .dtp_rvalid(rv[1]), .dtp_err(er[1]), .dtp_rdata(rd[1]),
    .dma_req(d_req[2]), .dma_addr(d_addr[2]), .dma_we(d_we[2]), .dma_wdata(d_wd[2]), .dma_be(d_be[2]),
    .dma_gnt(gnt[2]), .dma_rvalid(rv[2]), .dma_err(er[2]), .dma_rdata(rd[2])
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] ref_mem [8192];
  logic [32:0] q0 [$], q1 [$], q2 [$];
  string tg0 [$], tg1 [$], tg2 [$];
  bit mon_on = 0;

  function automatic bit in_win(int p, logic [16:0] a);
    if (p == 0) return a[16:15] == 2'b00;
    if (p == 1) return a[16:15] == 2'b10;
    return a[16:15] == 2'b00 || a[16:15] == 2'b10;
  endfunction

  function automatic void push(int p, logic [32:0] v, string t);
    case (p)
      0: begin q0.push_back(v); tg0.push_back(t); end
      1: begin q1.push_back(v); tg1.push_back(t); end
      default: begin q2.push_back(v); tg2.push_back(t); end
    endcase
  endfunction

  task automatic check(bit good, string t, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic setp(int p, bit rq, logic [16:0] a, bit w, logic [31:0] dat, logic [3:0] b);
    d_req[p] = rq; d_addr[p] = a; d_we[p] = w; d_wd[p] = dat; d_be[p] = b;
  endtask

  task automatic idle();
    d_req = '0; d_we = '0;
  endtask

  task automatic step(logic [2:0] exp, string t);
    @(negedge clk);
    #1;
    check(gnt === exp, {t, " grant"}, 64'(gnt), 64'(exp));
    for (int p = 0; p < 3; p++) begin
      if (gnt[p] && d_req[p]) begin
        if (!in_win(p, d_addr[p])) push(p, {1'b1, 32'h0}, t);
        else if (d_we[p]) begin
          for (int j = 0; j < 4; j++)
            if (d_be[p][j]) ref_mem[d_addr[p][14:2]][j*8 +: 8] = d_wd[p][j*8 +: 8];
        end else push(p, {1'b0, ref_mem[d_addr[p][14:2]]}, t);
      end
    end
    @(posedge clk);
    #1;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (mon_on) begin
        for (int p = 0; p < 3; p++) begin
          if (rv[p] || er[p]) begin
            logic [32:0] e;
            string t;
            bit have;
            have = (p == 0) ? q0.size() > 0 : (p == 1) ? q1.size() > 0 : q2.size() > 0;
            if (!have) check(0, $sformatf("R8 unexpected response port %0d", p), {31'h0, er[p], rd[p]}, 64'h0);
            else begin
              case (p)
                0: begin e = q0.pop_front(); t = tg0.pop_front(); end
                1: begin e = q1.pop_front(); t = tg1.pop_front(); end
                default: begin e = q2.pop_front(); t = tg2.pop_front(); end
              endcase
              check(rv[p] === ~e[32] && er[p] === e[32] && rd[p] === e[31:0],
                    {t, " response"}, {30'h0, er[p], rv[p], rd[p]}, {30'h0, e[32], ~e[32], e[31:0]});
            end
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    for (int p = 0; p < 3; p++) setp(p, 0, '0, 0, '0, '0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(gnt === 3'b0 && rv === 3'b0 && er === 3'b0, "R11 in reset", {gnt, rv, er}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check(gnt === 3'b0 && rv === 3'b0 && er === 3'b0, "R11 after reset", {gnt, rv, er}, 0);
    mon_on = 1;
    @(posedge clk); #1;

    // writes through each window and port (R1 R2 R3 R4)
    setp(0, 1, 17'h00010, 1, 32'h1111_0010, 4'hF); step(3'b001, "R1 ifp write low bank");
    setp(0, 1, 17'h04020, 1, 32'h2222_4020, 4'hF); step(3'b001, "R4 ifp write high bank");
    idle();
    setp(1, 1, 17'h10100, 1, 32'h3333_0100, 4'hF); step(3'b010, "R2 dtp write");
    idle();
    setp(2, 1, 17'h14200, 1, 32'h4444_4200, 4'hF); step(3'b100, "R3 dma write data window");
    idle();
    // aliasing reads
    setp(0, 1, 17'h00100, 0, '0, '0); step(3'b001, "R2 ifp reads dtp word");
    idle();
    setp(1, 1, 17'h10010, 0, '0, '0); step(3'b010, "R2 dtp reads ifp word");
    idle();
    setp(2, 1, 17'h04200, 0, '0, '0); step(3'b100, "R3 dma reads via instr window");
    setp(2, 1, 17'h14020, 0, '0, '0); step(3'b100, "R3 dma reads via data window");
    idle();
    // different banks concurrently (R5)
    setp(0, 1, 17'h00010, 0, '0, '0);
    setp(1, 1, 17'h14020, 0, '0, '0);
    step(3'b011, "R5 split-bank reads");
    idle();
    // same bank contention (R6)
    setp(0, 1, 17'h00010, 0, '0, '0);
    setp(1, 1, 17'h10100, 0, '0, '0);
    setp(2, 1, 17'h00100, 0, '0, '0);
    step(3'b001, "R6 ifp first");
    d_req[0] = 0;
    step(3'b010, "R6 dtp second");
    d_req[1] = 0;
    step(3'b100, "R6 dma last");
    idle();
    // byte strobes (R9)
    setp(1, 1, 17'h10010, 1, 32'hAABB_CCDD, 4'b0101); step(3'b010, "R9 strobed write");
    setp(1, 1, 17'h10010, 0, '0, '0); step(3'b010, "R9 strobed readback");
    idle();
    // out-of-window (R10)
    setp(0, 1, 17'h10000, 0, '0, '0); step(3'b001, "R10 ifp in data window");
    idle();
    setp(1, 1, 17'h00010, 1, 32'hDEAD_BEEF, 4'hF); step(3'b010, "R10 dtp write in instr window");
    idle();
    setp(2, 1, 17'h08000, 0, '0, '0); step(3'b100, "R10 dma gap address");
    idle();
    setp(0, 1, 17'h00010, 0, '0, '0); step(3'b001, "R10 word untouched");
    idle();
    // starvation guard (R7)
    setp(2, 1, 17'h00100, 0, '0, '0);
    for (int k = 0; k < 4; k++) begin
      setp(0, 1, 17'(17'h00040 + k*4), 1, 32'(32'h5000 + k), 4'hF);
      step(3'b001, "R7 dma denied");
    end
    setp(0, 1, 17'h00050, 1, 32'h6000, 4'hF);
    step(3'b100, "R7 dma boosted");
    d_req[2] = 0;
    step(3'b001, "R7 ifp resumes");
    idle();
    setp(0, 1, 17'h00040, 0, '0, '0); step(3'b001, "R7 readback ifp write");
    idle();
    repeat (3) @(posedge clk);
    #1;
    check(q0.size() == 0 && q1.size() == 0 && q2.size() == 0, "R8 all responses seen",
          64'(q0.size() + q1.size() + q2.size()), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule